// File: doc/BRIEF.md
# Level-to-Edge Interrupt Combiner

This block merges a set of level-sensitive interrupt requests into a single interrupt line meant for a processor input that only reacts to rising edges. Each request is first brought into the local clock domain, then gated by a per-source enable mask, and the enabled levels are ORed onto a registered output.

When a plain wired OR feeds an edge-only receiver, a second source can become active while the first is being serviced. The shared line then never falls, and the receiver never sees another edge. This block avoids that. A clear strobe, issued by software once it has serviced the sources, forces the output low. The output then stays low for a fixed minimum number of cycles. After that hold-off it rises again if any enabled source is still active, so every rearm gives the receiver a fresh edge.

Software reads two status vectors to find which sources need service: the synchronised raw levels, and the pending levels after the mask.

Top module: `irq_edge_combiner`

## Requirements
- R1: After reset, irq_o is 0, every mask bit is 0 (pend_status_o stays 0 whatever the requests do), and the hold-off timer is idle, so the first enabled request raises irq_o without waiting out a low period.
- R2: A level change on irq_req_i[i] appears on raw_status_o[i] after exactly two rising clock edges. Masked sources appear there too.
- R3: On a rising edge where mask_we_i is 1, the mask takes the value of mask_wdata_i. pend_status_o[i] equals raw_status_o[i] AND mask bit i, where bit i = 1 enables source i.
- R4: When no clear is in progress, irq_o is 1 one rising edge after pend_status_o becomes non-zero. A request therefore reaches irq_o on the third rising edge after it is applied.
- R5: When no clear is in progress, irq_o returns to 0 one rising edge after pend_status_o becomes all zero.
- R6: The rising edge that samples clr_i = 1 drives irq_o to 0, even while sources are still pending.
- R7: After a clear, irq_o stays 0 for exactly MIN_LOW cycles (parameter, at least 2). On the MIN_LOW-th rising edge after the clear edge it rises again if pend_status_o is non-zero.
- R8: If nothing is pending when the hold-off ends, irq_o stays 0. It rises later, under R4 timing, when a source becomes pending.
- R9: A clear that arrives while irq_o is already low restarts the hold-off count from the start. No pulse appears between the two clears.
- R10: A source whose mask bit is 0 never holds irq_o high and never raises it, but it still shows on raw_status_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req_i | input | NUM_SRC | Asynchronous level-sensitive requests, 1 = active |
| mask_we_i | input | 1 | Write strobe for the enable mask |
| mask_wdata_i | input | NUM_SRC | New mask value, bit i = 1 enables source i |
| clr_i | input | 1 | Service-done strobe, one cycle |
| irq_o | output | 1 | Combined interrupt output for an edge-detecting receiver |
| raw_status_o | output | NUM_SRC | Synchronised request levels, before the mask |
| pend_status_o | output | NUM_SRC | Synchronised request levels after the mask |

## Verification
The key corner case is a source that is still pending at a clear. A design that only ORs its inputs would keep the line high and never rearm. A design that counts the low period wrongly would rise one cycle early or late, so the bench checks both the last low cycle and the first high cycle. A second clear in the middle of the hold-off is checked every cycle: a timer that does not restart would emit an early pulse. The bench also sets requests on masked sources and checks them twice: before any mask write (testing the reset value of the mask) and under a partial mask, where they must show on raw status yet leave the output low.

// File: rtl/irqc_pkg.sv
// Package: shared types for the level-to-edge interrupt combiner.
// Assumes: nothing beyond a single clock domain for the consumers.
package irqc_pkg;

    // Output sequencer states: following the pending OR, or holding low after a clear
    typedef enum logic {
        SEQ_FOLLOW = 1'b0,
        SEQ_HOLD   = 1'b1
    } seq_state_t;

    // Clamp the programmable low time to the minimum that gives a visible edge
    function automatic int unsigned clamp_low(input int unsigned req);
        return (req < 2) ? 2 : req;
    endfunction

endpackage

// File: rtl/irqc_sync_bank.sv
// Module: irqc_sync_bank
// Brings NUM_SRC asynchronous level requests into the clk domain through
// two flops per bit. Assumes each request is a level that holds for
// several cycles; no pulse capture is attempted.
module irqc_sync_bank #(
    parameter int unsigned NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] async_i,
    output logic [NUM_SRC-1:0] sync_o
);

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
            logic meta_q;
            logic stab_q;

            // Two-stage synchroniser for one request bit
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    stab_q <= 1'b0;
                end else begin
                    meta_q <= async_i[g];
                    stab_q <= meta_q;
                end
            end

            assign sync_o[g] = stab_q;
        end
    endgenerate

endmodule

// File: rtl/irqc_mask_gate.sv
// Module: irqc_mask_gate
// Holds the per-source enable mask and applies it to the synchronised
// levels. Assumes mask writes come as single-cycle strobes from the
// surrounding register logic; the mask resets to all-disabled.
module irqc_mask_gate #(
    parameter int unsigned NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    input  logic [NUM_SRC-1:0] level_i,
    output logic [NUM_SRC-1:0] pend_o,
    output logic               any_o
);

    logic [NUM_SRC-1:0] mask_q;

    // Enable-mask register, loaded on write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (we_i) begin
            mask_q <= wdata_i;
        end
    end

    // Gate the levels and reduce to one request
    always_comb begin
        pend_o = level_i & mask_q;
        any_o  = |pend_o;
    end

endmodule

// File: rtl/irqc_rearm_seq.sv
// Module: irqc_rearm_seq
// Drives the registered interrupt output. In follow mode the output
// tracks the pending OR one edge later. A clear forces the output low
// and starts a hold-off of LOW_CYCLES cycles; a clear during the
// hold-off reloads it. Assumes LOW_CYCLES >= 2 (clamped by the caller).
module irqc_rearm_seq
    import irqc_pkg::*;
#(
    parameter int unsigned LOW_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic any_pend_i,
    input  logic clr_i,
    output logic irq_o
);

    localparam int unsigned CNT_W = $clog2(LOW_CYCLES);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(LOW_CYCLES - 1);

    seq_state_t     state_q;
    logic [CNT_W-1:0] cnt_q;
    logic           irq_q;

    // Sequencer: follow the OR, or hold low for the programmed time after a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_FOLLOW;
            cnt_q   <= '0;
            irq_q   <= 1'b0;
        end else if (clr_i) begin
            state_q <= SEQ_HOLD;
            cnt_q   <= RELOAD;
            irq_q   <= 1'b0;
        end else begin
            unique case (state_q)
                SEQ_FOLLOW: begin
                    irq_q <= any_pend_i;
                end
                SEQ_HOLD: begin
                    if (cnt_q == '0) begin
                        state_q <= SEQ_FOLLOW;
                        irq_q   <= any_pend_i;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                        irq_q <= 1'b0;
                    end
                end
                default: begin
                    state_q <= SEQ_FOLLOW;
                    irq_q   <= 1'b0;
                end
            endcase
        end
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/irq_edge_combiner.sv
// Module: irq_edge_combiner (top)
// Combines NUM_SRC level interrupt requests into one output for an
// edge-only receiver: synchronise, mask, OR, and rearm with a minimum
// low time after each software clear. Assumes clr_i and mask_we_i are
// synchronous to clk.
module irq_edge_combiner
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned MIN_LOW = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req_i,
    input  logic               mask_we_i,
    input  logic [NUM_SRC-1:0] mask_wdata_i,
    input  logic               clr_i,
    output logic               irq_o,
    output logic [NUM_SRC-1:0] raw_status_o,
    output logic [NUM_SRC-1:0] pend_status_o
);

    localparam int unsigned EFF_LOW = clamp_low(MIN_LOW);

    logic [NUM_SRC-1:0] sync_lvl;
    logic               any_pend;

    irqc_sync_bank #(.NUM_SRC(NUM_SRC)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_req_i),
        .sync_o  (sync_lvl)
    );

    irqc_mask_gate #(.NUM_SRC(NUM_SRC)) gate_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mask_we_i),
        .wdata_i (mask_wdata_i),
        .level_i (sync_lvl),
        .pend_o  (pend_status_o),
        .any_o   (any_pend)
    );

    irqc_rearm_seq #(.LOW_CYCLES(EFF_LOW)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_pend_i (any_pend),
        .clr_i      (clr_i),
        .irq_o      (irq_o)
    );

    assign raw_status_o = sync_lvl;

endmodule

// File: rtl/irq_edge_combiner_chk.sv
// Module: irq_edge_combiner_chk
// Port-level protocol checks for irq_edge_combiner, attached by bind.
// Assumes the same MIN_LOW clamp as the design.
module irq_edge_combiner_chk
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned MIN_LOW = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clr_i,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] pend_status_o
);

    localparam int unsigned EFF_LOW = clamp_low(MIN_LOW);

    int unsigned since_clr;

    // Cycles since the last clear, saturating at the low time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_clr <= EFF_LOW;
        end else if (clr_i) begin
            since_clr <= 0;
        end else if (since_clr < EFF_LOW) begin
            since_clr <= since_clr + 1;
        end
    end

    // R6
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !irq_o);

    // R7
    min_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (since_clr >= EFF_LOW));

    // R4
    rise_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(|pend_status_o));

    // R5
    hold_while_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !clr_i && (|pend_status_o)) |=> irq_o);

endmodule

bind irq_edge_combiner irq_edge_combiner_chk #(
    .NUM_SRC (NUM_SRC),
    .MIN_LOW (MIN_LOW)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .clr_i         (clr_i),
    .irq_o         (irq_o),
    .pend_status_o (pend_status_o)
);

// File: tb/irq_edge_combiner_tb_top.sv
module irq_edge_combiner_tb_top;

    localparam int unsigned N  = 8;
    localparam int unsigned ML = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic         mwe = 1'b0;
    logic [N-1:0] mdat = '0;
    logic         clr = 1'b0;
    logic         irq;
    logic [N-1:0] raw;
    logic [N-1:0] pend;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    irq_edge_combiner #(.NUM_SRC(N), .MIN_LOW(ML)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .irq_req_i     (req),
        .mask_we_i     (mwe),
        .mask_wdata_i  (mdat),
        .clr_i         (clr),
        .irq_o         (irq),
        .raw_status_o  (raw),
        .pend_status_o (pend)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_mask(input logic [N-1:0] v);
        mwe = 1'b1; mdat = v;
        tick(1);
        mwe = 1'b0;
    endtask

    // After return: one edge has sampled clr=1 (cycle j=1 of the hold-off)
    task automatic pulse_clear();
        clr = 1'b1;
        tick(1);
        clr = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        chk("R1 irq after reset", irq, 0);
        chk("R1 pend after reset", pend, 0);
        chk("R2 raw after reset", raw, 0);
    endtask

    task automatic t_masked_default();
        req = 8'h05;
        tick(1);
        chk("R2 raw one edge only", raw, 0);
        tick(1);
        chk("R2 raw after two edges", raw, 8'h05);
        tick(2);
        chk("R1 mask disabled pend", pend, 0);
        chk("R10 masked no irq", irq, 0);
    endtask

    task automatic t_enable();
        write_mask('1);
        chk("R3 pend after mask write", pend, 8'h05);
        chk("R4 irq one edge late", irq, 0);
        tick(1);
        chk("R4/R1 irq rises, no hold-off", irq, 1);
    endtask

    task automatic t_drop();
        req = '0;
        tick(2);
        chk("R2 raw drops", raw, 0);
        chk("R5 irq still high", irq, 1);
        tick(1);
        chk("R5 irq follows low", irq, 0);
    endtask

    task automatic t_clear_rearm();
        req = 8'h10;
        tick(2);
        chk("R4 irq not yet", irq, 0);
        tick(1);
        chk("R4 irq on third edge", irq, 1);
        pulse_clear();
        chk("R6 clear forces low", irq, 0);
        tick(ML - 1);
        chk("R7 last low cycle", irq, 0);
        tick(1);
        chk("R7 rearm edge", irq, 1);
    endtask

    task automatic t_clear_empty();
        req = '0;
        tick(3);
        chk("R5 irq low", irq, 0);
        pulse_clear();
        tick(ML + 2);
        chk("R8 nothing pending stays low", irq, 0);
        req = 8'h02;
        tick(3);
        chk("R8 later request raises", irq, 1);
    endtask

    task automatic t_restart();
        int lows = 0;
        pulse_clear();
        tick(1);
        chk("R9 low before second clear", irq, 0);
        pulse_clear();
        for (int k = 0; k < int'(ML) - 1; k++) begin
            if (irq == 1'b0) lows++;
            tick(1);
        end
        if (irq == 1'b0) lows++;
        chk("R9 no pulse during restarted hold", lows, ML);
        tick(1);
        chk("R9 rises after restarted hold", irq, 1);
    endtask

    task automatic t_partial_mask();
        write_mask(8'h01);
        chk("R10 pend masked", pend, 0);
        chk("R10 raw still shows", raw, 8'h02);
        tick(1);
        chk("R10 masked source releases irq", irq, 0);
        req = 8'h03;
        tick(3);
        chk("R3 enabled source pending", pend, 8'h01);
        chk("R4 enabled source drives irq", irq, 1);
    endtask

    initial begin
        t_reset();
        t_masked_default();
        t_enable();
        t_drop();
        t_clear_rearm();
        t_clear_empty();
        t_restart();
        t_partial_mask();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                total++;
                bad++;
                $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

endmodule